// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block runs the command and address phases of a small-page NAND flash with an 8-bit or 16-bit data bus. A host hands it a command byte, an optional column, an optional page number and two configuration bits: bus width and whether the device is larger than 32 MiB. The block then drives the latch-enable lines, write strobe, chip enable and data byte one cycle at a time. All timing comes from counts of the system clock, which are derived from the clock frequency parameter.

For a program-data-input command, the block first sends a read-pointer command. It picks that command from the column range and rebases the column to match. For page reads, it keeps chip enable low from the first page byte through the busy interval after the address phase. It waits the write-to-busy time, then checks the ready line once per microsecond up to a limit. It drops chip enable when the device reports ready or when the limit runs out. A reset command waits without limit for ready. Program, erase, status and data-input commands finish as soon as their bytes are out.

The host starts an operation with a one-cycle `start` while `busy` is low. It learns of completion from a one-cycle `done`, with `timed_out` telling whether a read poll gave up.

Top module: `nand_cmd_seq`

## Requirements
- R1: For command 0x80 the block first sends a pointer command, chosen as follows. If the column is absent or below 256, it sends 0x00 and the column unchanged. If the column is 256 or more but below PAGE_BYTES (512), it sends 0x01 and the column minus 256. If the column is PAGE_BYTES or more, it sends 0x50 and the column minus PAGE_BYTES.
- R2: Command bytes go out with flash_cle=1 and flash_ale=0. Address bytes go out with flash_ale=1 and flash_cle=0. The order is: command bytes, then the column byte (if present), then the page bytes (if present). No address byte is sent when neither column nor page is present.
- R3: With bus16=1 the column is shifted right by one bit after any R1 rebasing, and the low 8 bits are sent as one address byte.
- R4: Page bytes go out as page[7:0], then page[15:8]. A third byte {4'b0, page[19:16]} follows only when chip_large=1.
- R5: For read commands 0x00, 0x01 and 0x50 that carry a page, flash_ce_n stays low without a break from the first page byte until `done`. flash_ce_n is high in reset and in the cycle after `done`.
- R6: After the address phase of such a read, the block waits at least TWB_NS. It then samples ready (flash_rb_n high, through a two-flop synchronizer) once per microsecond. It finishes with timed_out=0 once ready is seen.
- R7: If ready is not seen within POLL_LIMIT (30) microsecond waits, the read finishes with timed_out=1. This takes at least POLL_LIMIT*CLK_MHZ cycles.
- R8: Commands 0x80, 0x10, 0x60, 0xD0 and 0x70 finish right after their last byte, whatever the level of flash_rb_n, with timed_out=0.
- R9: Command 0xFF, and any other command not covered by R6 or R8, waits TWB_NS and then waits without limit for ready. Chip enable is not held low during that wait.
- R10: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` lasts one cycle. `start` is ignored while `busy` is high.
- R11: Each byte is written by one low pulse of flash_we_n lasting WE_PULSE cycles (40 ns at 50 MHz). The pulse has WE_SETUP cycles before it and WE_HOLD cycles after it. flash_dq stays stable while flash_we_n is low, and flash_ce_n is low during the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when busy is low) |
| cmd_code | input | 8 | Command byte |
| col_present | input | 1 | Column address is supplied |
| col_addr | input | COL_W | Column address |
| page_present | input | 1 | Page address is supplied |
| page_addr | input | PAGE_W | Page address |
| bus16 | input | 1 | Device uses a 16-bit bus |
| chip_large | input | 1 | Device is larger than 32 MiB (third page byte) |
| flash_rb_n | input | 1 | Ready/busy from the device, low while busy |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| timed_out | output | 1 | Last read poll ended without ready |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_we_n | output | 1 | Write strobe, active low |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_dq | output | 8 | Data bus byte |

## Verification
The bench aims at the three column ranges of the pointer prefix. A design that compares against the wrong bound or forgets to rebase would send 0x00 or an unadjusted column where 0x01 or 0x50 is needed. It checks the 16-bit shift together with the conditional third page byte, which would catch a missing shift or a third byte sent for a small device. It holds ready low through a read to check that chip enable never lifts and that the timeout arrives only after the full poll budget, so an early give-up or a lost override shows at the pins. With ready still low, it checks that status and erase return at once, that reset keeps waiting past the poll budget with chip enable high, and that a start issued during that wait is dropped.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] CMD_READ0     = 8'h00;
  localparam logic [7:0] CMD_READ1     = 8'h01;
  localparam logic [7:0] CMD_READSPARE = 8'h50;
  localparam logic [7:0] CMD_SEQIN     = 8'h80;
  localparam logic [7:0] CMD_PROG      = 8'h10;
  localparam logic [7:0] CMD_ERASE1    = 8'h60;
  localparam logic [7:0] CMD_ERASE2    = 8'hD0;
  localparam logic [7:0] CMD_STATUS    = 8'h70;
  localparam logic [7:0] CMD_RESET     = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_CMD, ST_COL, ST_PG0, ST_PG1, ST_PG2,
    ST_TWB, ST_POLL, ST_USW, ST_DONE
  } seq_st_e;

  function automatic logic is_read_cmd(input logic [7:0] c);
    return (c == CMD_READ0) || (c == CMD_READ1) || (c == CMD_READSPARE);
  endfunction

  function automatic logic is_nowait_cmd(input logic [7:0] c);
    return (c == CMD_SEQIN) || (c == CMD_PROG) || (c == CMD_ERASE1) ||
           (c == CMD_ERASE2) || (c == CMD_STATUS);
  endfunction

  // Pointer command placed ahead of a data-input command.
  function automatic logic [7:0] pick_prefix(input logic cv, input logic [15:0] col,
                                             input logic [15:0] pbytes);
    if (cv && col >= pbytes)      return CMD_READSPARE;
    else if (cv && col >= 16'd256) return CMD_READ1;
    else                           return CMD_READ0;
  endfunction

  // Column byte as it goes on the bus: rebased for data input, halved for x16.
  function automatic logic [7:0] col_addr_byte(input logic seqin, input logic cv,
                                               input logic [15:0] col,
                                               input logic [15:0] pbytes,
                                               input logic wide);
    logic [15:0] c;
    c = col;
    if (seqin && cv) begin
      if (c >= pbytes)       c = c - pbytes;
      else if (c >= 16'd256) c = c - 16'd256;
    end
    if (wide) c = c >> 1;
    return c[7:0];
  endfunction

endpackage

// File: rtl/nand_we_strobe.sv
module nand_we_strobe #(
  parameter int SETUP = 1,
  parameter int PULSE = 2,
  parameter int HOLD  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] byte_in,
  output logic       active,
  output logic       fin,
  output logic       we_n,
  output logic [7:0] dq
);
  localparam int TOT = SETUP + PULSE + HOLD;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      dq     <= 8'h00;
    end else if (go && !active) begin
      active <= 1'b1;
      cnt    <= '0;
      dq     <= byte_in;
    end else if (active) begin
      if (cnt == CW'(TOT - 1)) active <= 1'b0;
      else                     cnt    <= cnt + 1'b1;
    end
  end

  assign fin  = active && (cnt == CW'(TOT - 1));
  assign we_n = !(active && (cnt >= CW'(SETUP)) && (cnt < CW'(SETUP + PULSE)));

endmodule

// File: rtl/nand_delay_timer.sv
module nand_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 50,
  parameter int TWB_NS     = 100,
  parameter int POLL_LIMIT = 30,
  parameter int WE_SETUP   = 1,
  parameter int WE_PULSE   = 2,
  parameter int WE_HOLD    = 1,
  parameter int PAGE_BYTES = 512,
  parameter int COL_W      = 10,
  parameter int PAGE_W     = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        cmd_code,
  input  logic              col_present,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              page_present,
  input  logic [PAGE_W-1:0] page_addr,
  input  logic              bus16,
  input  logic              chip_large,
  input  logic              flash_rb_n,
  output logic              busy,
  output logic              done,
  output logic              timed_out,
  output logic              flash_cle,
  output logic              flash_ale,
  output logic              flash_we_n,
  output logic              flash_ce_n,
  output logic [7:0]        flash_dq
);
  localparam int TWB_CYC = (TWB_NS * CLK_MHZ + 999) / 1000 + 1;
  localparam int US_CYC  = CLK_MHZ;
  localparam int TMR_MAX = (TWB_CYC > US_CYC) ? TWB_CYC : US_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PL_W    = $clog2(POLL_LIMIT + 1);

  seq_st_e           st, st_nx;
  logic [7:0]        cmd_r;
  logic              cv_r, pv_r, w16_r, big_r;
  logic [COL_W-1:0]  col_r;
  logic [PAGE_W-1:0] pg_r;
  logic              ovr, launched, timed_out_r;
  logic [PL_W-1:0]   polls_left;
  logic [1:0]        rb_sync;
  logic              ready_s;

  // Named internal events, also used by the checker.
  logic       byte_go, byte_fin, byte_active;
  logic       tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic       ev_ovr_set, ev_timeout, ev_ready;
  logic [7:0] tx_byte;
  seq_st_e    after_addr;

  assign ready_s = rb_sync[1];

  nand_we_strobe #(.SETUP(WE_SETUP), .PULSE(WE_PULSE), .HOLD(WE_HOLD)) u_strobe (
    .clk(clk), .rst_n(rst_n), .go(byte_go), .byte_in(tx_byte),
    .active(byte_active), .fin(byte_fin), .we_n(flash_we_n), .dq(flash_dq)
  );

  nand_delay_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    after_addr = is_nowait_cmd(cmd_r) ? ST_DONE : ST_TWB;
    case (st)
      ST_PRE:  tx_byte = pick_prefix(cv_r, 16'(col_r), 16'(PAGE_BYTES));
      ST_CMD:  tx_byte = cmd_r;
      ST_COL:  tx_byte = col_addr_byte(cmd_r == CMD_SEQIN, cv_r, 16'(col_r),
                                       16'(PAGE_BYTES), w16_r);
      ST_PG0:  tx_byte = pg_r[7:0];
      ST_PG1:  tx_byte = pg_r[15:8];
      ST_PG2:  tx_byte = {4'b0000, pg_r[19:16]};
      default: tx_byte = 8'h00;
    endcase
  end

  always_comb begin
    st_nx      = st;
    byte_go    = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    ev_ovr_set = 1'b0;
    ev_timeout = 1'b0;
    ev_ready   = 1'b0;
    if ((st == ST_PRE || st == ST_CMD || st == ST_COL || st == ST_PG0 ||
         st == ST_PG1 || st == ST_PG2) && !launched)
      byte_go = 1'b1;
    case (st)
      ST_IDLE: if (start) st_nx = (cmd_code == CMD_SEQIN) ? ST_PRE : ST_CMD;
      ST_PRE:  if (byte_fin) st_nx = ST_CMD;
      ST_CMD:  if (byte_fin) st_nx = cv_r ? ST_COL : (pv_r ? ST_PG0 : after_addr);
      ST_COL:  if (byte_fin) st_nx = pv_r ? ST_PG0 : after_addr;
      ST_PG0:  if (byte_fin) begin
                 st_nx      = ST_PG1;
                 ev_ovr_set = is_read_cmd(cmd_r);
               end
      ST_PG1:  if (byte_fin) st_nx = big_r ? ST_PG2 : after_addr;
      ST_PG2:  if (byte_fin) st_nx = after_addr;
      ST_TWB:  if (!launched) begin
                 tmr_load = 1'b1;
                 tmr_val  = TMR_W'(TWB_CYC);
               end else if (tmr_zero) st_nx = ST_POLL;
      ST_POLL: if (ready_s) begin
                 ev_ready = 1'b1;
                 st_nx    = ST_DONE;
               end else if (ovr) begin
                 if (polls_left == '0) begin
                   ev_timeout = 1'b1;
                   st_nx      = ST_DONE;
                 end else st_nx = ST_USW;
               end
      ST_USW:  if (!launched) begin
                 tmr_load = 1'b1;
                 tmr_val  = TMR_W'(US_CYC);
               end else if (tmr_zero) st_nx = ST_POLL;
      ST_DONE: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cmd_r       <= 8'h00;
      cv_r        <= 1'b0;
      pv_r        <= 1'b0;
      w16_r       <= 1'b0;
      big_r       <= 1'b0;
      col_r       <= '0;
      pg_r        <= '0;
      ovr         <= 1'b0;
      launched    <= 1'b0;
      timed_out_r <= 1'b0;
      polls_left  <= '0;
      rb_sync     <= 2'b00;
    end else begin
      st      <= st_nx;
      rb_sync <= {rb_sync[0], flash_rb_n};
      if (st_nx != st) launched <= 1'b0;
      else if (byte_go || tmr_load) launched <= 1'b1;
      if (st == ST_IDLE && start) begin
        cmd_r       <= cmd_code;
        cv_r        <= col_present;
        col_r       <= col_addr;
        pv_r        <= page_present;
        pg_r        <= page_addr;
        w16_r       <= bus16;
        big_r       <= chip_large;
        timed_out_r <= 1'b0;
        polls_left  <= PL_W'(POLL_LIMIT);
      end
      if (ev_ovr_set) ovr <= 1'b1;
      else if (st == ST_DONE) ovr <= 1'b0;
      if (ev_timeout) timed_out_r <= 1'b1;
      if (st == ST_USW && launched && tmr_zero) polls_left <= polls_left - 1'b1;
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_DONE);
  assign timed_out  = timed_out_r;
  assign flash_cle  = (st == ST_PRE) || (st == ST_CMD);
  assign flash_ale  = (st == ST_COL) || (st == ST_PG0) || (st == ST_PG1) || (st == ST_PG2);
  assign flash_ce_n = !(byte_active || ovr);

endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       timed_out,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       ce_n,
  input logic [7:0] dq,
  input logic       ovr_evt
);

  assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  assert_we_needs_ce_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  assert_dq_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(dq));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_timeout_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> done);

  assert_ce_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> !ce_n);

  assert_ce_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ce_n);

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .timed_out(timed_out),
  .cle(flash_cle), .ale(flash_ale), .we_n(flash_we_n), .ce_n(flash_ce_n),
  .dq(flash_dq), .ovr_evt(ev_ovr_set)
);

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic        col_present = 1'b0;
  logic [9:0]  col_addr = '0;
  logic        page_present = 1'b0;
  logic [19:0] page_addr = '0;
  logic        bus16 = 1'b0;
  logic        chip_large = 1'b0;
  logic        flash_rb_n = 1'b1;
  logic        busy, done, timed_out, flash_cle, flash_ale, flash_we_n, flash_ce_n;
  logic [7:0]  flash_dq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  nand_cmd_seq u_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
    .col_present(col_present), .col_addr(col_addr), .page_present(page_present),
    .page_addr(page_addr), .bus16(bus16), .chip_large(chip_large),
    .flash_rb_n(flash_rb_n), .busy(busy), .done(done), .timed_out(timed_out),
    .flash_cle(flash_cle), .flash_ale(flash_ale), .flash_we_n(flash_we_n),
    .flash_ce_n(flash_ce_n), .flash_dq(flash_dq)
  );

  // Bus monitor: one log entry per write strobe.
  logic [7:0] log_b [16];
  logic       log_c [16];
  logic       log_a [16];
  int         nlog = 0;
  int         wbad = 0;
  int         wseen = 0;
  realtime    t_fall = 0.0;

  always @(negedge flash_we_n) t_fall = $realtime;
  always @(posedge flash_we_n) if (rst_n) begin
    wseen++;
    if (($realtime - t_fall) < 39.9 || ($realtime - t_fall) > 40.1) wbad++;
    if (nlog < 16) begin
      log_b[nlog] = flash_dq;
      log_c[nlog] = flash_cle;
      log_a[nlog] = flash_ale;
    end
    nlog++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // kind: 2 = command byte (CLE), 1 = address byte (ALE)
  task automatic chk_byte(input int idx, input int kind, input int val, input string req);
    int k;
    k = {log_c[idx], log_a[idx]};
    chk(k == kind, req, k, kind);
    chk(log_b[idx] == val[7:0], req, log_b[idx], val);
  endtask

  task automatic issue(input logic [7:0] c, input logic cv, input logic [9:0] col,
                       input logic pv, input logic [19:0] pg, input logic w, input logic big);
    @(negedge clk);
    nlog = 0;
    cmd_code = c; col_present = cv; col_addr = col; page_present = pv;
    page_addr = pg; bus16 = w; chip_large = big; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int maxc, output bit got, output bit tout, output int cyc);
    got = 0; tout = 0; cyc = 0;
    while (cyc < maxc && !got) begin
      @(negedge clk);
      cyc++;
      if (done) begin got = 1; tout = timed_out; end
    end
  endtask

  task automatic t_reset_state();
    chk(busy == 0, "R10 idle busy", busy, 0);
    chk(flash_ce_n == 1, "R5 idle ce_n", flash_ce_n, 1);
    chk(flash_we_n == 1 && flash_cle == 0 && flash_ale == 0, "R2 idle strobes",
        {flash_we_n, flash_cle, flash_ale}, 3'b100);
  endtask

  task automatic t_seqin(input logic [9:0] col, input int pre, input int cb, input string req);
    bit got, tout; int cyc;
    flash_rb_n = 1'b1;
    issue(8'h80, 1'b1, col, 1'b1, 20'h12345, 1'b0, 1'b0);
    wait_done(200, got, tout, cyc);
    chk(got && !tout, {req, " R8 seqin done"}, {got, tout}, 2'b10);
    chk(nlog == 5, {req, " R4 byte count"}, nlog, 5);
    chk_byte(0, 2, pre, {req, " R1 prefix"});
    chk_byte(1, 2, 8'h80, {req, " R2 cmd"});
    chk_byte(2, 1, cb, {req, " R1 column"});
    chk_byte(3, 1, 8'h45, "R4 page low");
    chk_byte(4, 1, 8'h23, "R4 page mid");
  endtask

  task automatic t_status_nowait();
    bit got, tout; int cyc;
    flash_rb_n = 1'b0;
    issue(8'h70, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    wait_done(40, got, tout, cyc);
    chk(got && !tout, "R8 status returns with rb low", {got, tout}, 2'b10);
    chk(nlog == 1, "R2 status has no address bytes", nlog, 1);
    chk_byte(0, 2, 8'h70, "R2 status cmd");
  endtask

  task automatic t_erase_nowait();
    bit got, tout; int cyc;
    flash_rb_n = 1'b0;
    issue(8'h60, 1'b0, '0, 1'b1, 20'hF0A5C, 1'b0, 1'b0);
    wait_done(80, got, tout, cyc);
    chk(got && !tout, "R8 erase setup returns with rb low", {got, tout}, 2'b10);
    chk(nlog == 3, "R4 small chip two page bytes", nlog, 3);
    chk_byte(1, 1, 8'h5C, "R4 erase page low");
    chk_byte(2, 1, 8'h0A, "R4 erase page mid");
  endtask

  task automatic t_read_ready();
    bit got, tout; int cyc; int guard;
    flash_rb_n = 1'b0;
    issue(8'h00, 1'b1, 10'd500, 1'b1, 20'hABCDE, 1'b1, 1'b1);
    guard = 0;
    while (nlog < 5 && guard < 200) begin @(negedge clk); guard++; end
    chk(nlog == 5, "R4 large chip three page bytes", nlog, 5);
    chk_byte(0, 2, 8'h00, "R2 read cmd");
    chk_byte(1, 1, 8'hFA, "R3 x16 column shift");
    chk_byte(2, 1, 8'hDE, "R4 page low");
    chk_byte(3, 1, 8'hBC, "R4 page mid");
    chk_byte(4, 1, 8'h0A, "R4 page high masked");
    repeat (200) @(negedge clk);
    chk(flash_ce_n == 0, "R5 ce held during read busy", flash_ce_n, 0);
    chk(busy == 1, "R6 still waiting before ready", busy, 1);
    flash_rb_n = 1'b1;
    wait_done(120, got, tout, cyc);
    chk(got && !tout, "R6 read finishes on ready", {got, tout}, 2'b10);
    @(negedge clk);
    chk(flash_ce_n == 1, "R5 ce released after done", flash_ce_n, 1);
    chk(done == 0 && busy == 0, "R10 done one cycle", {done, busy}, 0);
  endtask

  task automatic t_read_timeout();
    bit got, tout; int cyc; int celow;
    flash_rb_n = 1'b0;
    issue(8'h01, 1'b1, 10'd7, 1'b1, 20'h00321, 1'b0, 1'b0);
    celow = 1; cyc = 0; got = 0; tout = 0;
    while (cyc < 3000 && !got) begin
      @(negedge clk);
      cyc++;
      if (nlog >= 3 && !done && flash_ce_n) celow = 0;
      if (done) begin got = 1; tout = timed_out; end
    end
    chk(celow == 1, "R5 ce never lifts during poll", celow, 1);
    chk(got && tout, "R7 timeout flagged", {got, tout}, 2'b11);
    chk(cyc >= 1500 && cyc <= 1800, "R7 timeout after poll budget", cyc, 1500);
    @(negedge clk);
    chk(flash_ce_n == 1, "R5 ce released after timeout", flash_ce_n, 1);
    flash_rb_n = 1'b1;
  endtask

  task automatic t_reset_cmd();
    bit got, tout; int cyc; int cehi;
    flash_rb_n = 1'b0;
    issue(8'hFF, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    cehi = 1; got = 0;
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      if (done) got = 1;
      if (i > 20 && !flash_ce_n) cehi = 0;
      if (i == 100) start = 1'b1;
      if (i == 100) cmd_code = 8'h70;
      if (i == 101) start = 1'b0;
    end
    chk(got == 0, "R9 reset waits past poll budget", got, 0);
    chk(cehi == 1, "R9 ce not held in reset wait", cehi, 1);
    chk(nlog == 1, "R10 start ignored while busy", nlog, 1);
    flash_rb_n = 1'b1;
    wait_done(20, got, tout, cyc);
    chk(got && !tout, "R9 reset ends on ready", {got, tout}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_seqin(10'd10,  8'h00, 8'h0A, "R1 low range");
    t_seqin(10'd300, 8'h01, 8'h2C, "R1 mid range");
    t_seqin(10'd515, 8'h50, 8'h03, "R1 spare range");
    t_status_nowait();
    t_erase_nowait();
    t_read_ready();
    t_read_timeout();
    t_reset_cmd();
    chk(wseen > 20 && wbad == 0, "R11 we pulse width", wbad, 0);
    report();
    $finish;
  end

endmodule